// File: doc/BRIEF.md
# CPU Cycle and Bus-Phase Generator

This block turns a fast master clock into the timing skeleton of a processor bus cycle. It divides the master clock by a region-dependent integer (12, 16 or 15) so that one processor cycle spans that many master clocks. Within each cycle it drives two complementary internal phase enables: the first phase covers the opening half of the cycle and the second phase covers the closing half. It also drives an external bus strobe, `m2`, that is high only in the tail of the cycle. That high window is longer than half a cycle so that slow memories get more access time. On two of the regions the window is an odd number of half master clocks, so the rising edge of `m2` lands on a falling master-clock edge.

A processor cycle begins at the instant `m2` falls. A one-master-clock pulse, `cyc_start`, marks the first master clock of every cycle. After a synchronous reset is released, the block counts falls of `m2`. After the sixth fall it raises `reset_done`, which a core uses to hold off its start-up sequence. A change of the region select is taken only at a cycle boundary, so no cycle is ever cut short or stretched.

Top module: `cpu_bus_clkgen`

## Requirements
- R1: The cycle length in master clocks follows `region_sel`: 0 gives 12, 1 gives 16, 2 gives 15, and the spare code 3 behaves as 0 (12).
- R2: While running, exactly one of `phi1`/`phi2` is high. `phi1` is high for the first floor(D/2) master clocks of a D-clock cycle and `phi2` for the remaining clocks, which is exactly half each for even D.
- R3: `m2` falls only on a rising master-clock edge, at the same edge that starts a cycle. It is then high for 15 half master clocks per cycle when D=12, 19 when D=16 and 18 when D=15, ending at the end of the cycle.
- R4: When the `m2` high time is an odd number of half clocks, `m2` rises on a falling master-clock edge. Otherwise it rises on a rising edge.
- R5: `cyc_start` is high for exactly the first master clock of every cycle and low in every other master clock.
- R6: Reset is synchronous and active low. While it is held, `phi1`, `phi2`, `m2`, `cyc_start` and `reset_done` are all low.
- R7: The first rising edge that sees `rst_n` high starts the first cycle, so `cyc_start` is high in the master clock that follows that edge.
- R8: `reset_done` is low until the cycle that begins at the sixth `m2` fall after reset release. It rises at that cycle's start and stays high until the next reset.
- R9: A new `region_sel` value affects only the cycles that begin after it is presented. A cycle that is in progress keeps the length and `m2` window it started with.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous active-low reset |
| region_sel | input | 2 | Region code selecting divisor and strobe window |
| phi1 | output | 1 | Internal first-half phase enable |
| phi2 | output | 1 | Internal second-half phase enable |
| m2 | output | 1 | External bus strobe, high in the stretched cycle tail |
| cyc_start | output | 1 | One-master-clock pulse in the first clock of each cycle |
| reset_done | output | 1 | High once six strobe cycles have completed after reset |

## Verification
The bench samples every half master clock. This lets it measure the `m2` window in half-clock units and tell whether the strobe rose on a rising or a falling edge. A shaper that dropped the half-clock stage would show 16 or 20 half clocks instead of 15 or 19. Region codes are changed mid-cycle at several offsets. A design that latched the select at once would produce a cycle whose length matches neither the old nor the new divisor. It also sweeps the spare code and counts `m2` falls against the rise of `reset_done`, which exposes an off-by-one in the start-up counter as a flag one cycle early or late.

// File: rtl/busclk_pkg.sv
`timescale 1ns/1ps
// Shared types for the bus-phase generator.
// Assumes region codes are two bits wide; code 3 is a spare that maps to code 0.
package busclk_pkg;

    typedef enum logic [1:0] {
        RGN_0   = 2'd0,
        RGN_1   = 2'd1,
        RGN_2   = 2'd2,
        RGN_RSV = 2'd3
    } rgn_e;

    // Largest of three integers, used to size the cycle counter.
    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/bclk_cycle_counter.sv
`timescale 1ns/1ps
// Counts master clocks inside one processor cycle and holds the region
// code that applies to the current cycle. The region code is sampled only
// at a cycle boundary (or while idle), so the current cycle keeps its length.
// Assumes every divisor is at least 2 and fits in CNT_W+1 bits.
module bclk_cycle_counter
    import busclk_pkg::*;
#(
    parameter int DIV0  = 12,
    parameter int DIV1  = 16,
    parameter int DIV2  = 15,
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [1:0]       region_sel,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W:0]   div_cur,
    output rgn_e             region_cur,
    output logic             last
);

    localparam logic [CNT_W:0] D0 = DIV0[CNT_W:0];
    localparam logic [CNT_W:0] D1 = DIV1[CNT_W:0];
    localparam logic [CNT_W:0] D2 = DIV2[CNT_W:0];

    // Divisor for the region code held for this cycle.
    always_comb begin
        case (region_cur)
            RGN_1:   div_cur = D1;
            RGN_2:   div_cur = D2;
            default: div_cur = D0;
        endcase
    end

    // Final master clock of the cycle.
    assign last = run && ({1'b0, cnt} == (div_cur - 1'b1));

    // Advance the count; take a new region code only at a boundary or while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt        <= '0;
            region_cur <= rgn_e'(region_sel);
        end else if (!run) begin
            region_cur <= rgn_e'(region_sel);
        end else if (last) begin
            cnt        <= '0;
            region_cur <= rgn_e'(region_sel);
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // R1
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, cnt} < div_cur));

    // R1
    wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        last |=> (cnt == '0));

    // R9
    region_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !last) |=> $stable(region_cur));

endmodule

// File: rtl/bclk_m2_shaper.sv
`timescale 1ns/1ps
// Builds the external strobe. It is high in the tail of each cycle for a
// count of half master clocks. An odd count is produced by ANDing the
// count decode with a copy of it retimed on the falling master edge, which
// delays only the rising edge by half a clock.
// Assumes the high time is shorter than the cycle, so the decode is low at count 0.
module bclk_m2_shaper #(
    parameter int CNT_W    = 4,
    parameter bit HAS_HALF = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W:0]   div_cur,
    input  logic [CNT_W+1:0] high_halves,
    output logic             m2
);

    logic [CNT_W+1:0] tail_clks;
    logic [CNT_W+1:0] rise_at;
    logic             win;

    // Whole master clocks spanned by the window, rounded up, and where it opens.
    always_comb begin
        tail_clks = (high_halves + 1'b1) >> 1;
        rise_at   = {1'b0, div_cur} - tail_clks;
    end

    // Window decode straight from the count register.
    assign win = run && ({2'b00, cnt} >= rise_at);

    generate
        if (HAS_HALF) begin : g_half
            logic win_neg;

            // Retime the window on the falling master edge.
            always_ff @(negedge clk) begin
                if (!rst_n) begin
                    win_neg <= 1'b0;
                end else begin
                    win_neg <= win;
                end
            end

            // Odd counts open half a clock late; both forms close at cycle end.
            assign m2 = win && (high_halves[0] ? win_neg : 1'b1);
        end else begin : g_whole
            assign m2 = win;
        end
    endgenerate

    // R3
    start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '0) |-> !win);

endmodule

// File: rtl/bclk_boot_counter.sv
`timescale 1ns/1ps
// Counts completed strobe cycles after reset and raises a flag once
// DONE_CYCLES of them have finished. The flag then holds until reset.
// Assumes the wrap input is high for exactly the last clock of each cycle.
module bclk_boot_counter #(
    parameter int DONE_CYCLES = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wrap,
    output logic done
);

    localparam int             BW    = $clog2(DONE_CYCLES + 1);
    localparam int             LASTI = DONE_CYCLES - 1;
    localparam logic [BW-1:0]  LAST  = LASTI[BW-1:0];

    logic [BW-1:0] seen;

    // Count strobe falls until the limit, then latch the flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen <= '0;
            done <= 1'b0;
        end else if (wrap && !done) begin
            seen <= seen + 1'b1;
            if (seen == LAST) begin
                done <= 1'b1;
            end
        end
    end

    // R8
    done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done);

    // R8
    done_at_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(wrap));

endmodule

// File: rtl/cpu_bus_clkgen.sv
`timescale 1ns/1ps
// Processor cycle and bus-phase generator. It divides the master clock by a
// region-selected integer and drives two complementary phase enables, a
// stretched external strobe, a cycle-start pulse and a start-up done flag.
// Assumes a single master clock domain and a synchronous active-low reset.
module cpu_bus_clkgen
    import busclk_pkg::*;
#(
    parameter int DIV0        = 12,
    parameter int DIV1        = 16,
    parameter int DIV2        = 15,
    parameter int M2H0        = 15,
    parameter int M2H1        = 19,
    parameter int M2H2        = 18,
    parameter int DONE_CYCLES = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] region_sel,
    output logic       phi1,
    output logic       phi2,
    output logic       m2,
    output logic       cyc_start,
    output logic       reset_done
);

    localparam int  MAXD     = max3(DIV0, DIV1, DIV2);
    localparam int  CNT_W    = $clog2(MAXD);
    localparam bit  HAS_HALF = ((M2H0 % 2) + (M2H1 % 2) + (M2H2 % 2)) != 0;
    localparam logic [CNT_W+1:0] H0 = M2H0[CNT_W+1:0];
    localparam logic [CNT_W+1:0] H1 = M2H1[CNT_W+1:0];
    localparam logic [CNT_W+1:0] H2 = M2H2[CNT_W+1:0];

    logic             run;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W:0]   div_cur;
    logic [CNT_W:0]   half_d;
    logic [CNT_W+1:0] high_halves;
    rgn_e             region_cur;
    logic             last;

    // Goes high at the first edge that sees reset released.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run <= 1'b0;
        end else begin
            run <= 1'b1;
        end
    end

    bclk_cycle_counter #(
        .DIV0  (DIV0),
        .DIV1  (DIV1),
        .DIV2  (DIV2),
        .CNT_W (CNT_W)
    ) counter_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run),
        .region_sel (region_sel),
        .cnt        (cnt),
        .div_cur    (div_cur),
        .region_cur (region_cur),
        .last       (last)
    );

    // Strobe high time, in half master clocks, for the current region.
    always_comb begin
        case (region_cur)
            RGN_1:   high_halves = H1;
            RGN_2:   high_halves = H2;
            default: high_halves = H0;
        endcase
    end

    bclk_m2_shaper #(
        .CNT_W    (CNT_W),
        .HAS_HALF (HAS_HALF)
    ) shaper_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .run         (run),
        .cnt         (cnt),
        .div_cur     (div_cur),
        .high_halves (high_halves),
        .m2          (m2)
    );

    bclk_boot_counter #(
        .DONE_CYCLES (DONE_CYCLES)
    ) boot_i (
        .clk   (clk),
        .rst_n (rst_n),
        .wrap  (last),
        .done  (reset_done)
    );

    // Phase split at half the divisor; the start pulse marks count zero.
    always_comb begin
        half_d    = div_cur >> 1;
        phi1      = run && ({1'b0, cnt} < half_d);
        phi2      = run && !({1'b0, cnt} < half_d);
        cyc_start = run && (cnt == '0);
    end

    // R2
    phase_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (phi1 != phi2));

    // R6
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> (!phi1 && !phi2 && !m2 && !cyc_start && !reset_done));

    // R3
    m2_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(m2) |-> cyc_start);

    // R5
    start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_start |=> !cyc_start);

endmodule

// File: tb/cpu_bus_clkgen_tb_top.sv
`timescale 1ns/1ps
// Half-clock sampling bench for the bus-phase generator.
module cpu_bus_clkgen_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] region_sel = 2'd0;
    logic       phi1, phi2, m2, cyc_start, reset_done;

    int checks = 0;
    int fails  = 0;

    // Measurement state for the cycle in progress
    bit started, fresh, prev_m2, rise_lo, seen_rise;
    int idx, clk_n, m2_h, p1_n, p2_n, exp_d, exp_h;

    always #4 clk = ~clk;

    cpu_bus_clkgen dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .region_sel (region_sel),
        .phi1       (phi1),
        .phi2       (phi2),
        .m2         (m2),
        .cyc_start  (cyc_start),
        .reset_done (reset_done)
    );

    function automatic int div_of(input int r);
        case (r)
            1:       return 16;
            2:       return 15;
            default: return 12;
        endcase
    endfunction

    function automatic int h_of(input int d);
        case (d)
            16:      return 19;
            15:      return 18;
            default: return 15;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Close a fully observed cycle: R1 length, R2 phases, R3 window, R4 edge.
    task automatic end_cycle();
        chk(clk_n == exp_d, "R1", "cycle length", clk_n, exp_d);
        chk(p1_n == exp_d / 2, "R2", "phi1 clocks", p1_n, exp_d / 2);
        chk(p2_n == exp_d - exp_d / 2, "R2", "phi2 clocks", p2_n, exp_d - exp_d / 2);
        chk(m2_h == exp_h, "R3", "m2 high halves", m2_h, exp_h);
        chk(seen_rise && (rise_lo == exp_h[0]), "R4", "m2 rise on falling edge",
            int'(rise_lo), exp_h % 2);
    endtask

    // Sample taken in the high half of the master clock.
    task automatic do_hi();
        bit boundary;
        boundary = fresh || (prev_m2 && !m2);
        if (fresh) begin
            chk(cyc_start == 1'b1, "R7", "start right after release", int'(cyc_start), 1);
        end
        chk(cyc_start == boundary, "R5", "start pulse placement", int'(cyc_start), int'(boundary));
        if (boundary) begin
            if (started) end_cycle();
            started = 1'b1;
            fresh   = 1'b0;
            idx++;
            chk(reset_done == (idx >= 7), "R8", "done flag at cycle start",
                int'(reset_done), int'(idx >= 7));
            exp_d = div_of(int'(region_sel));
            exp_h = h_of(exp_d);
            clk_n = 0; m2_h = 0; p1_n = 0; p2_n = 0;
            seen_rise = 1'b0; rise_lo = 1'b0;
        end
        if (started) begin
            clk_n++;
            p1_n += int'(phi1);
            p2_n += int'(phi2);
            chk(phi1 != phi2, "R2", "phases complementary", int'(phi1), int'(!phi2));
            if (m2 && !prev_m2) begin seen_rise = 1'b1; rise_lo = 1'b0; end
            m2_h += int'(m2);
        end
        prev_m2 = m2;
    endtask

    // Sample taken in the low half of the master clock.
    task automatic do_lo();
        if (started) begin
            chk(!(prev_m2 && !m2), "R3", "m2 fell on falling edge", int'(m2), 1);
            chk(phi1 != phi2, "R2", "phases complementary", int'(phi1), int'(!phi2));
            if (m2 && !prev_m2) begin seen_rise = 1'b1; rise_lo = 1'b1; end
            m2_h += int'(m2);
        end
        prev_m2 = m2;
    endtask

    // Hold reset for three clocks with region r; outputs must stay low (R6).
    task automatic apply_reset(input int r);
        rst_n      = 1'b0;
        region_sel = 2'(r);
        for (int i = 0; i < 3; i++) begin
            @(posedge clk); #2;
            chk(!phi1 && !phi2 && !m2 && !cyc_start && !reset_done, "R6",
                "outputs low in reset",
                int'({phi1, phi2, m2, cyc_start, reset_done}), 0);
            @(negedge clk); #2;
            chk(!m2, "R6", "m2 low in reset (low phase)", int'(m2), 0);
        end
        rst_n   = 1'b1;
        started = 1'b0;
        fresh   = 1'b1;
        prev_m2 = 1'b0;
        idx     = 0;
    endtask

    // Run n master clocks; optionally change region mid-stream (R9).
    task automatic run_clocks(input int n, input int change_at, input int new_r);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #2;
            do_hi();
            if (i == change_at) region_sel = 2'(new_r);
            @(negedge clk); #2;
            do_lo();
        end
    endtask

    initial begin
        started = 1'b0; fresh = 1'b0; prev_m2 = 1'b0;
        rise_lo = 1'b0; seen_rise = 1'b0;
        idx = 0; clk_n = 0; m2_h = 0; p1_n = 0; p2_n = 0; exp_d = 12; exp_h = 15;
        @(negedge clk); #2;
        // R1: sweep every region code, including the spare
        for (int r = 0; r < 4; r++) begin
            apply_reset(r);
            run_clocks(220, -1, r);
        end
        // R9: region changes at assorted offsets inside running cycles
        run_clocks(40, 7, 1);
        run_clocks(40, 13, 2);
        run_clocks(40, 5, 3);
        run_clocks(40, 20, 0);
        run_clocks(40, 3, 2);
        run_clocks(40, 11, 1);
        run_clocks(40, -1, 1);
        // Reset again mid-cycle and confirm the start-up count restarts (R8)
        apply_reset(2);
        run_clocks(150, -1, 2);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    // Watchdog
    initial begin
        #1600000;
        checks++;
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule